// File: doc/BRIEF.md
# Bus-State-Aware Video Port Decoder

This block decides, on every bus cycle of a 16-bit processor backplane, whether the video port card should take part. It looks at the address, the read/write strobe, the memory-cycle flag, the three bus-status bits and a per-page flag that marks a page as holding memory-mapped ports. From these it produces four registered one-hot select lines, one for each video port.

Two operating modes place the ports at different addresses. In the legacy interpreter mode, reads and writes of the video data go to separate addresses. In the native mode, one address serves both data read and data write. There, a byte move first issues a dummy read of its destination operand. That read would step the video chip's auto-incrementing address counter. The decoder detects this fetch from the bus-status code and blocks the select. It then raises a bus-override output that disables every card's address decoder. It also drives 0x0000 onto the data bus, so the bus does not float during that read.

Top module: `vport_decode`

## Requirements
- R1: While rst_n is low, vsel, override and drv_en are all 0 and drv_data is 0x0000, whatever the bus inputs are.
- R2: No select, override or data drive is produced unless page_port is 1.
- R3: In legacy mode (mode_native=0), a read of 0x8800+2i or a write of 0x8C00+2i selects port i (i=0..3). A read of a write address, a write of a read address, and any other address select nothing.
- R4: In native mode (mode_native=1), a read or a write of 0xF100+2i selects port i (i=0..3). Any other address, odd ones included, selects nothing.
- R5: A select is registered. It appears on vsel bit i from the first rising clock edge at which cyc_act is 1. It stays there while cyc_act is 1, and vsel never has more than one bit set.
- R6: A destination-operand fetch is coded as rd_wr=1, mem_flag=0 and bst=3'b100 (bst[2] is the first status bit). A read with mem_flag=1 or with any other bst value is an ordinary access.
- R7: In native mode, a destination-operand fetch of 0xF100 with page_port=1 is suppressed. vsel stays 0, override and drv_en go to 1 at the first edge of the cycle, and drv_data is 0x0000. The same fetch at the other native port addresses is not suppressed.
- R8: A read of 0xF100 that is not a destination-operand fetch selects port 0 normally.
- R9: vsel, override and drv_en return to 0 at the first rising edge at which cyc_act is 0.
- R10: Legacy mode never suppresses. A destination-operand fetch of 0x8800 selects port 0 and leaves override at 0.
- R11: A byte move to 0xF100 in native mode (a destination-operand fetch followed by a write) produces exactly one rising edge on vsel[0]. A plain read and a plain write each produce exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_act | input | 1 | Address strobe; high for the duration of a bus cycle |
| addr | input | 16 | Byte address of the current cycle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| mem_flag | input | 1 | Memory-cycle flag from the processor |
| bst | input | 3 | Bus-status bits, bst[2] first |
| page_port | input | 1 | Current page holds memory-mapped ports |
| mode_native | input | 1 | 1 = native mode, 0 = legacy mode |
| vsel | output | 4 | Registered one-hot video port selects |
| override | output | 1 | Bus-master override, disables card decoders |
| drv_en | output | 1 | Enable for the local data-bus drive |
| drv_data | output | 16 | Value to drive on the data bus during a suppressed read |

## Verification
The assertions assume that cyc_act separates bus cycles by at least one idle clock. They also assume that the address, direction, status bits, page flag and mode stay stable while cyc_act is high. The stimulus changes every bus input only on a falling edge that opens a new cycle. After each cycle it drops cyc_act for one clock before the next begins. The random cycles choose from addresses at and next to the port locations in both modes. They give the destination-fetch status code about half the time, so suppressed and unsuppressed cycles are both common.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
   typedef enum logic {
      MODE_LEGACY = 1'b0,
      MODE_NATIVE = 1'b1
   } vpd_mode_e;

   localparam int          BST_W   = 3;
   localparam logic [2:0]  BST_DOP = 3'b100;
endpackage

// File: rtl/vpd_match.sv
module vpd_match #(
   parameter int                ADDR_W      = 16,
   parameter int                NPORTS      = 4,
   parameter logic [ADDR_W-1:0] LEG_RD_BASE = 16'h8800,
   parameter logic [ADDR_W-1:0] LEG_WR_BASE = 16'h8C00,
   parameter logic [ADDR_W-1:0] NAT_BASE    = 16'hF100
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  vpd_pkg::vpd_mode_e mode,
   output logic [NPORTS-1:0] hit
);
   localparam int SPAN = 2 * NPORTS;

   if ((LEG_RD_BASE % SPAN) != 0 || (LEG_WR_BASE % SPAN) != 0 ||
       (NAT_BASE % SPAN) != 0) begin : g_bad_base
      $error("vpd_match: port bases must be aligned to the port span");
   end

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(2 * i);
      logic leg_hit;
      logic nat_hit;
      assign leg_hit = rd ? (addr == LEG_RD_BASE + OFS)
                          : (addr == LEG_WR_BASE + OFS);
      assign nat_hit = (addr == NAT_BASE + OFS);
      assign hit[i]  = (mode == vpd_pkg::MODE_NATIVE) ? nat_hit : leg_hit;
   end
endmodule

// File: rtl/vpd_dop.sv
module vpd_dop #(
   parameter int             BST_W    = vpd_pkg::BST_W,
   parameter logic [BST_W-1:0] DOP_CODE = vpd_pkg::BST_DOP
) (
   input  logic             rd,
   input  logic             mem_flag,
   input  logic [BST_W-1:0] bst,
   output logic             is_dop
);
   if (BST_W < 1) begin : g_bad_w
      $error("vpd_dop: status width must be at least one bit");
   end

   always_comb begin
      is_dop = 1'b0;
      if (rd && !mem_flag && (bst == DOP_CODE)) begin
         is_dop = 1'b1;
      end
   end
endmodule

// File: rtl/vpd_outreg.sv
module vpd_outreg #(
   parameter int                NPORTS = 4,
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] FILL   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_act,
   input  logic [NPORTS-1:0] sel_d,
   input  logic              sup_d,
   input  logic              native,
   output logic [NPORTS-1:0] vsel,
   output logic              override,
   output logic              drv_en,
   output logic [DATA_W-1:0] drv_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsel     <= '0;
         override <= 1'b0;
         drv_en   <= 1'b0;
      end else begin
         vsel     <= cyc_act ? sel_d : '0;
         override <= cyc_act & sup_d;
         drv_en   <= cyc_act & sup_d;
      end
   end

   assign drv_data = drv_en ? FILL : '0;

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vsel));

   p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_act |=> (vsel == '0));

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_act |=> (!override && !drv_en));

   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      override |-> (vsel == '0));

   p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      override |-> (drv_en && drv_data == FILL));

   p_legacy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !native |=> !override);
endmodule

// File: rtl/vport_decode.sv
module vport_decode #(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 16,
   parameter int                NPORTS      = 4,
   parameter logic [ADDR_W-1:0] LEG_RD_BASE = 16'h8800,
   parameter logic [ADDR_W-1:0] LEG_WR_BASE = 16'h8C00,
   parameter logic [ADDR_W-1:0] NAT_BASE    = 16'hF100,
   parameter logic [DATA_W-1:0] FILL        = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_act,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_wr,
   input  logic              mem_flag,
   input  logic [2:0]        bst,
   input  logic              page_port,
   input  logic              mode_native,
   output logic [NPORTS-1:0] vsel,
   output logic              override,
   output logic              drv_en,
   output logic [DATA_W-1:0] drv_data
);
   import vpd_pkg::*;

   if (NPORTS < 2 || (NPORTS & (NPORTS - 1)) != 0) begin : g_bad_np
      $error("vport_decode: port count must be a power of two >= 2");
   end
   if (ADDR_W < 8 || DATA_W < 1) begin : g_bad_w
      $error("vport_decode: bus widths out of range");
   end

   vpd_mode_e         mode;
   logic [NPORTS-1:0] hit;
   logic              is_dop;
   logic              sup;
   logic [NPORTS-1:0] sel_d;

   assign mode = mode_native ? MODE_NATIVE : MODE_LEGACY;

   vpd_match #(
      .ADDR_W(ADDR_W), .NPORTS(NPORTS), .LEG_RD_BASE(LEG_RD_BASE),
      .LEG_WR_BASE(LEG_WR_BASE), .NAT_BASE(NAT_BASE)
   ) u_match (
      .addr(addr), .rd(rd_wr), .mode(mode), .hit(hit)
   );

   vpd_dop #(
      .BST_W(BST_W), .DOP_CODE(BST_DOP)
   ) u_dop (
      .rd(rd_wr), .mem_flag(mem_flag), .bst(bst), .is_dop(is_dop)
   );

   // hit[0] in native mode is the shared data address
   assign sup   = (mode == MODE_NATIVE) && page_port && is_dop && hit[0];
   assign sel_d = page_port ? (hit & ~{NPORTS{sup}}) : '0;

   vpd_outreg #(
      .NPORTS(NPORTS), .DATA_W(DATA_W), .FILL(FILL)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .sel_d(sel_d),
      .sup_d(sup), .native(mode_native), .vsel(vsel),
      .override(override), .drv_en(drv_en), .drv_data(drv_data)
   );
endmodule

// File: tb/sim_vport_decode.sv
`timescale 1ns/1ps
module sim_vport_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_act = 1'b0;
   logic [15:0] addr = '0;
   logic        rd_wr = 1'b0;
   logic        mem_flag = 1'b0;
   logic [2:0]  bst = '0;
   logic        page_port = 1'b0;
   logic        mode_native = 1'b0;
   logic [3:0]  vsel;
   logic        override;
   logic        drv_en;
   logic [15:0] drv_data;

   int checks = 0;
   int errors = 0;
   int rise_cnt [4];
   logic [3:0] vsel_prev = '0;
   bit done = 0;

   always #5 clk = ~clk;

   vport_decode u0 (
      .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .addr(addr),
      .rd_wr(rd_wr), .mem_flag(mem_flag), .bst(bst),
      .page_port(page_port), .mode_native(mode_native), .vsel(vsel),
      .override(override), .drv_en(drv_en), .drv_data(drv_data)
   );

   initial for (int i = 0; i < 4; i++) rise_cnt[i] = 0;

   always @(negedge clk) begin
      for (int i = 0; i < 4; i++)
         if (vsel[i] && !vsel_prev[i]) rise_cnt[i] = rise_cnt[i] + 1;
      vsel_prev = vsel;
   end

   // -1: nothing, -2: suppressed, else port index
   function automatic int ref_port(logic nat, logic [15:0] a, logic rd,
                                   logic mf, logic [2:0] b, logic pg);
      if (!pg) return -1;
      if (nat) begin
         if (a[15:3] == 13'h1E20 && !a[0]) begin
            if (a == 16'hF100 && rd && !mf && b == 3'b100) return -2;
            return int'(a[2:1]);
         end
         return -1;
      end
      if (rd && a[15:3] == 13'h1100 && !a[0]) return int'(a[2:1]);
      if (!rd && a[15:3] == 13'h1180 && !a[0]) return int'(a[2:1]);
      return -1;
   endfunction

   task automatic check(string req, int exp, string what);
      logic [3:0] ev;
      logic       eo;
      ev = (exp >= 0) ? (4'b0001 << exp) : 4'b0000;
      eo = (exp == -2);
      checks++;
      if (vsel !== ev || override !== eo || drv_en !== eo || drv_data !== 16'h0000) begin
         errors++;
         $display("FAIL %s %s: vsel=%b ovr=%b drv=%b data=%h expected vsel=%b ovr=%b drv=%b data=0000",
                  req, what, vsel, override, drv_en, drv_data, ev, eo, eo);
      end
   endtask

   task automatic do_cyc(logic nat, logic [15:0] a, logic rd, logic mf,
                         logic [2:0] b, logic pg, string req);
      int e;
      @(negedge clk);
      mode_native = nat; addr = a; rd_wr = rd; mem_flag = mf;
      bst = b; page_port = pg; cyc_act = 1'b1;
      e = ref_port(nat, a, rd, mf, b, pg);
      @(negedge clk);
      check((e == -2) ? "R7" : "R5", e, $sformatf("%s first edge a=%h", req, a));
      @(negedge clk);
      check(req, e, $sformatf("%s held a=%h", req, a));
      cyc_act = 1'b0;
      @(negedge clk);
      check("R9", -1, $sformatf("%s after end a=%h", req, a));
   endtask

   task automatic cnt_check(string req, int base, int exp);
      checks++;
      if (rise_cnt[0] - base != exp) begin
         errors++;
         $display("FAIL %s access count=%0d expected %0d", req, rise_cnt[0] - base, exp);
      end
   endtask

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] pool [16] = '{16'h8800, 16'h8802, 16'h8804, 16'h8806,
                                 16'h8C00, 16'h8C02, 16'h8C04, 16'h8C06,
                                 16'hF100, 16'hF102, 16'hF104, 16'hF106,
                                 16'hF101, 16'hF108, 16'h8801, 16'h1234};
      int b0;
      void'($urandom(32'd11));
      // R1: inputs active during reset
      mode_native = 1'b1; addr = 16'hF100; rd_wr = 1'b1; mem_flag = 1'b0;
      bst = 3'b100; page_port = 1'b1; cyc_act = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", -1, "in reset");
      cyc_act = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", -1, "after reset");

      // legacy
      do_cyc(0, 16'h8800, 1, 1, 3'b000, 1, "R3");
      do_cyc(0, 16'h8C02, 0, 1, 3'b000, 1, "R3");
      do_cyc(0, 16'h8C00, 1, 1, 3'b000, 1, "R3");
      do_cyc(0, 16'h8806, 1, 1, 3'b010, 1, "R3");
      do_cyc(0, 16'h8800, 1, 0, 3'b100, 1, "R10");
      // native
      do_cyc(1, 16'hF100, 0, 1, 3'b000, 1, "R4");
      do_cyc(1, 16'hF102, 1, 1, 3'b000, 1, "R4");
      do_cyc(1, 16'hF106, 0, 1, 3'b000, 1, "R4");
      do_cyc(1, 16'hF101, 1, 1, 3'b000, 1, "R4");
      do_cyc(1, 16'hF100, 1, 0, 3'b100, 1, "R7");
      do_cyc(1, 16'hF102, 1, 0, 3'b100, 1, "R7");
      do_cyc(1, 16'hF100, 1, 0, 3'b110, 1, "R8");
      do_cyc(1, 16'hF100, 1, 1, 3'b100, 1, "R6");
      do_cyc(1, 16'hF100, 1, 0, 3'b100, 0, "R2");
      do_cyc(0, 16'h8800, 1, 1, 3'b000, 0, "R2");

      // R11 byte move, plain read, plain write
      b0 = rise_cnt[0];
      do_cyc(1, 16'hF100, 1, 0, 3'b100, 1, "R11");
      do_cyc(1, 16'hF100, 0, 1, 3'b000, 1, "R11");
      cnt_check("R11 byte move", b0, 1);
      b0 = rise_cnt[0];
      do_cyc(1, 16'hF100, 1, 1, 3'b000, 1, "R11");
      cnt_check("R11 plain read", b0, 1);
      b0 = rise_cnt[0];
      do_cyc(1, 16'hF100, 0, 1, 3'b000, 1, "R11");
      cnt_check("R11 plain write", b0, 1);
      b0 = rise_cnt[0];
      do_cyc(0, 16'h8800, 1, 0, 3'b100, 1, "R10");
      cnt_check("R10 legacy dop", b0, 1);

      // random
      for (int n = 0; n < 400; n++) begin
         logic [2:0] rb;
         rb = ($urandom % 2) ? 3'b100 : 3'($urandom);
         do_cyc(1'($urandom), pool[$urandom % 16], 1'($urandom),
                (($urandom % 4) == 0), rb, (($urandom % 8) != 0), "R4/R3 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule